// File: doc/BRIEF.md
# Pointing-Device Change Interrupt Port

This block watches a small group of asynchronous input lines, such as the quadrature and button lines of a mouse, and raises an interrupt whenever their sampled state no longer matches the state the processor last read. The lines are first synchronized and then captured into a holding register. That register is frozen while a read is in progress, so the value returned cannot move under the reader.

A read puts the captured value on an 8-bit data bus, with the upper bits set to zero. The same read copies that value into a reference register. One access therefore both acknowledges the interrupt and re-arms change detection. After reset, the block waits for the first genuine sample and adopts it as the reference without raising an interrupt.

Top module: `ptr_change_port`

## Requirements
- R1: While reset is asserted, `irq` is 0 and `rd_data` is 0, including when `rd_stb` is high.
- R2: After reset, the first synchronized sample becomes the reference without asserting `irq`. A later read returns that sample.
- R3: A change on `raw_in` that is held stable appears on `irq` after exactly three rising clock edges, and not after only two.
- R4: On the clock edge where `rd_stb` is high, the captured value is copied into the reference. `irq` is then 0 for as long as the strobe stays high.
- R5: While `rd_stb` is high, `rd_data[LINES-1:0]` holds the captured value and the upper bits of `rd_data` are 0. While `rd_stb` is low, `rd_data` is 0.
- R6: While `rd_stb` is held high, the captured value does not change. A change on `raw_in` during the strobe is detected after the strobe is released.
- R7: The comparison is level-based, not sticky. If the inputs return to the reference value before any read, `irq` falls again three edges later.
- R8: Without a read, the reference never changes. `irq` stays high for as long as the captured value differs from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_in | input | LINES | Asynchronous device lines |
| rd_stb | input | 1 | Port read strobe (address decode done outside) |
| rd_data | output | 8 | Read data, zero-extended captured value |
| irq | output | 1 | Change interrupt request |

## Verification
The assertions assume that `rd_stb` is synchronous to `clk` and that reset is released away from a clock edge. The bench drives every input, including `raw_in`, on the falling edge, so the synchronizer never sees a metastable sample. They also assume that a change on `raw_in` only counts once it has been held for three edges. The stimulus holds each new input value for at least three cycles before judging `irq`, except for the deliberate two-edge probe that checks the latency lower bound.

// File: rtl/ptr_change_port.sv
module ptr_change_port #(
  parameter int LINES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_in,
  input  logic             rd_stb,
  output logic [7:0]       rd_data,
  output logic             irq
);

  localparam int FILL = SYNC_STAGES + 1;
  localparam int FW   = $clog2(FILL + 1);

  logic [LINES-1:0] sync_q [SYNC_STAGES];
  logic [LINES-1:0] cap_q, ref_q;
  logic [FW-1:0]    fill_q;
  logic             primed_q;
  logic             cap_valid;

  assign cap_valid = (fill_q == FW'(FILL));

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= '0;
        else if (g == 0) sync_q[g] <= raw_in;
        else sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
    end else if (!cap_valid) begin
      fill_q <= fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else if (!rd_stb) cap_q <= sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q    <= '0;
      primed_q <= 1'b0;
    end else if (cap_valid && (rd_stb || !primed_q)) begin
      ref_q    <= cap_q;
      primed_q <= 1'b1;
    end
  end

  assign irq     = primed_q && (cap_q != ref_q);
  assign rd_data = rd_stb ? 8'(cap_q) : 8'h00;

  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && cap_valid) |=> (!rd_stb || !irq));

  p_capture_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> (!rd_stb || $stable(cap_q)));

  p_prime_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !primed_q) |=> !irq);

  p_ref_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && !rd_stb) |=> $stable(ref_q));

endmodule

// File: tb/ptr_change_port_tb.sv
module ptr_change_port_tb;
  localparam int LINES = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b1;
  logic [LINES-1:0] raw_in = '0;
  logic             rd_stb = 1'b0;
  logic [7:0]       rd_data;
  logic             irq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ptr_change_port #(.LINES(LINES)) u_dut (
    .clk(clk), .rst_n(rst_n), .raw_in(raw_in),
    .rd_stb(rd_stb), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Read the port: check data while the strobe is up, then the cleared irq.
  task automatic do_read(input int exp_val, input string req);
    rd_stb = 1'b1;
    #1;
    chk(req, int'(rd_data), exp_val);
    @(negedge clk);
    chk("R4", int'(irq), 0);
    rd_stb = 1'b0;
    #1;
    chk("R5", int'(rd_data), 0);
  endtask

  initial begin
    #2 rst_n = 1'b0;
    raw_in = 4'd5;
    rd_stb = 1'b1;
    cyc(3);
    chk("R1", int'(irq), 0);
    chk("R1", int'(rd_data), 0);
    rd_stb = 1'b0;
    rst_n = 1'b1;
    // R2: first sample adopted quietly
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R2", int'(irq), 0);
    end
    do_read(5, "R2");

    // R3/R4/R5: exhaustive pairs of reference and new value
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        raw_in = 4'(a);
        cyc(4);
        do_read(a, "R5");
        raw_in = 4'(b);
        cyc(2);
        chk("R3", int'(irq), 0);
        cyc(1);
        chk("R3", int'(irq), (a != b) ? 1 : 0);
        do_read(b, "R5");
      end
    end

    // R7: returning to the reference drops irq
    raw_in = 4'd3; cyc(4); do_read(3, "R5");
    raw_in = 4'd4; cyc(3);
    chk("R7", int'(irq), 1);
    raw_in = 4'd3; cyc(3);
    chk("R7", int'(irq), 0);

    // R8: irq holds without a read
    raw_in = 4'd9; cyc(3);
    for (int i = 0; i < 10; i++) begin
      chk("R8", int'(irq), 1);
      cyc(1);
    end
    do_read(9, "R8");

    // R6: capture frozen during a long strobe
    rd_stb = 1'b1;
    #1;
    chk("R6", int'(rd_data), 9);
    raw_in = 4'd12;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R6", int'(rd_data), 9);
      chk("R6", int'(irq), 0);
    end
    rd_stb = 1'b0;
    cyc(1);
    chk("R6", int'(irq), 1);
    do_read(12, "R6");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule